// File: doc/BRIEF.md
# Latched Interrupt Mask Controller

This block collects requests from seven external interrupt lines. Each line passes through a synchronizer, and a rising edge on the line sets a sticky latch for that source. A mask register that software can write decides which latched sources reach the pending register. The pending register can only be read. Masking is applied after the latch, so a source that arrives while its mask bit is closed stays latched. It shows up as pending as soon as software opens that mask bit.

The block is reached through a simple byte-wide register port, with an address offset, write and read strobes, and write and read data. Software reads the pending register to find which sources need service. It clears latches by writing ones to the pending offset. Whenever anything is pending, a level interrupt output is high and a summary bit is set in the status byte handed to the neighbouring status logic. A synchronous system reset and a separate soft reset both close the mask and empty the latches.

Top module: `irq_mask_ctrl`

## Requirements
- R1: After system reset, the mask reads 0x00 at offset 0x83, the pending register reads 0x00 at offset 0x82, and `irq_o` and `status_bits_o` are 0.
- R2: A one-cycle pulse on `soft_rst_i` clears the mask to 0x00 and clears all latches. Opening the mask to 0xFF afterwards shows no pending bits.
- R3: A rising edge on interrupt input n (n from 1 to 7, line `irq_req_i[n-1]`) sets latch bit n-1 even while mask bit n-1 is 0. If the input is high at one clock edge, the pending bit is visible after the second clock edge that follows it.
- R4: Reading offset 0x82 returns the bitwise AND of the latches and the mask in bits 6..0. Bit 7 always reads 0.
- R5: A write to offset 0x83 loads all 8 bits of the mask, and the value can be read back at 0x83. Mask bit value 1 passes a source and 0 blocks it. 0x04 passes only input 3, 0xFF passes every input and 0x00 blocks all of them.
- R6: Writing to offset 0x82 clears each latch whose data bit is 1 and leaves the other latches unchanged. It does not alter the mask.
- R7: If a new rising edge on an input is detected in the same cycle as a clear of that latch, the latch stays set.
- R8: `irq_o` is 1 exactly when the pending register is nonzero. Bit 2 of `status_bits_o` follows `irq_o`, and the other status bits are 0.
- R9: Reading any offset other than 0x82 or 0x83 returns 0x00. `bus_rdata_o` is 0x00 while `bus_rd_i` is low. A write to an unmapped offset changes neither the mask nor the latches.
- R10: A line held high does not set its latch again after it has been cleared. Only a new rising edge sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous system reset, active high |
| soft_rst_i | input | 1 | Synchronous soft reset, active high; clears mask and latches |
| irq_req_i | input | 7 | Asynchronous interrupt request lines, input n on bit n-1 |
| bus_addr_i | input | 8 | Register offset |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_rd_i | input | 1 | Read strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid combinationally while `bus_rd_i` is high |
| irq_o | output | 1 | Level interrupt, high while any pending bit is set |
| status_bits_o | output | 8 | Contribution to the status byte; bit 2 is the summary pending flag |

## Verification
Two functions can meet in one cycle: the edge detector setting a latch, and a software clear of that same latch. The bench raises an input and counts the register stages in the synchronizer, so that the clear write is sampled on exactly the clock edge where the detected edge sets the latch. It then expects the pending bit to remain set. A second case holds a line high across a clear and expects the bit to stay cleared. Together the two cases separate a true new edge from a level that is still high.

// File: rtl/irq_mask_pkg.sv
package irq_mask_pkg;

    localparam int BYTE_W       = 8;
    localparam int ADDR_W       = 8;
    localparam int SRC_MAX      = 7;
    localparam int STAT_PEND_B  = 2;

    localparam logic [ADDR_W-1:0] OFS_PEND = 8'h82;
    localparam logic [ADDR_W-1:0] OFS_MASK = 8'h83;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_PEND = 2'd1,
        SEL_MASK = 2'd2
    } reg_sel_e;

    typedef struct packed {
        logic              wr;
        logic              rd;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] wdata;
    } bus_req_t;

    function automatic reg_sel_e decode_ofs(input logic [ADDR_W-1:0] a);
        if (a == OFS_PEND)      return SEL_PEND;
        else if (a == OFS_MASK) return SEL_MASK;
        else                    return SEL_NONE;
    endfunction

endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
    parameter int N_SRC  = 7,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [N_SRC-1:0] req_i,
    output logic [N_SRC-1:0] edge_o
);

    for (genvar g = 0; g < N_SRC; g++) begin : g_line
        logic [STAGES-1:0] sh_q;
        logic              prev_q;

        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                sh_q   <= '0;
                prev_q <= 1'b0;
            end else begin
                sh_q   <= {sh_q[STAGES-2:0], req_i[g]};
                prev_q <= sh_q[STAGES-1];
            end
        end

        assign edge_o[g] = sh_q[STAGES-1] & ~prev_q;
    end

endmodule

// File: rtl/irq_latch_bank.sv
module irq_latch_bank #(
    parameter int N_SRC = 7
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             soft_rst_i,
    input  logic [N_SRC-1:0] edge_i,
    input  logic [N_SRC-1:0] clr_i,
    output logic [N_SRC-1:0] latch_o
);

    logic [N_SRC-1:0] latch_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || soft_rst_i) latch_q <= '0;
        else                     latch_q <= (latch_q & ~clr_i) | edge_i;
    end

    assign latch_o = latch_q;

    // R1
    rst_clears_latch_chk: assert property (@(posedge clk_i)
        rst_i |=> (latch_q == '0));

    // R2
    soft_clears_latch_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        soft_rst_i |=> (latch_q == '0));

    // R3
    edge_sets_latch_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!soft_rst_i && edge_i != '0) |=> ((latch_q & $past(edge_i)) == $past(edge_i)));

    // R7
    clear_no_edge_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (clr_i != '0) |=> ((latch_q & $past(clr_i & ~edge_i)) == '0));

    // R10
    rise_needs_edge_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> ((latch_q & ~$past(latch_q) & ~$past(edge_i)) == '0));

endmodule

// File: rtl/irq_reg_if.sv
module irq_reg_if
    import irq_mask_pkg::*;
#(
    parameter int N_SRC = 7
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              soft_rst_i,
    input  bus_req_t          bus_i,
    input  logic [N_SRC-1:0]  latch_i,
    output logic [N_SRC-1:0]  clr_o,
    output logic [N_SRC-1:0]  pend_o,
    output logic [BYTE_W-1:0] rdata_o
);

    reg_sel_e          sel;
    logic [BYTE_W-1:0] mask_q;
    logic [BYTE_W-1:0] pend_byte;
    logic              mask_wr;

    assign sel     = decode_ofs(bus_i.addr);
    assign mask_wr = bus_i.wr && (sel == SEL_MASK);

    always_ff @(posedge clk_i) begin
        if (rst_i || soft_rst_i) mask_q <= '0;
        else if (mask_wr)        mask_q <= bus_i.wdata;
    end

    assign pend_o = latch_i & mask_q[N_SRC-1:0];
    assign clr_o  = (bus_i.wr && sel == SEL_PEND) ? bus_i.wdata[N_SRC-1:0] : '0;

    always_comb begin
        pend_byte            = '0;
        pend_byte[N_SRC-1:0] = pend_o;
    end

    always_comb begin
        rdata_o = '0;
        if (bus_i.rd) begin
            case (sel)
                SEL_PEND: rdata_o = pend_byte;
                SEL_MASK: rdata_o = mask_q;
                default:  rdata_o = '0;
            endcase
        end
    end

    // R1
    rst_closes_mask_chk: assert property (@(posedge clk_i)
        rst_i |=> (mask_q == '0));

    // R2
    soft_closes_mask_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        soft_rst_i |=> (mask_q == '0));

    // R6
    mask_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!soft_rst_i && !(bus_i.wr && bus_i.addr == OFS_MASK)) |=> $stable(mask_q));

    // R5
    mask_load_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!soft_rst_i && bus_i.wr && bus_i.addr == OFS_MASK) |=> (mask_q == $past(bus_i.wdata)));

    // R9
    idle_read_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!bus_i.rd || (bus_i.addr != OFS_PEND && bus_i.addr != OFS_MASK)) |-> (rdata_o == '0));

endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl
    import irq_mask_pkg::*;
#(
    parameter int N_SRC       = SRC_MAX,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              soft_rst_i,
    input  logic [N_SRC-1:0]  irq_req_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [BYTE_W-1:0] bus_wdata_i,
    output logic [BYTE_W-1:0] bus_rdata_o,
    output logic              irq_o,
    output logic [BYTE_W-1:0] status_bits_o
);

    bus_req_t         bus;
    logic [N_SRC-1:0] edge_w;
    logic [N_SRC-1:0] clr_w;
    logic [N_SRC-1:0] latch_w;
    logic [N_SRC-1:0] pend_w;

    assign bus.wr    = bus_wr_i;
    assign bus.rd    = bus_rd_i;
    assign bus.addr  = bus_addr_i;
    assign bus.wdata = bus_wdata_i;

    irq_edge_sync #(.N_SRC(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .req_i  (irq_req_i),
        .edge_o (edge_w)
    );

    irq_latch_bank #(.N_SRC(N_SRC)) u_latch (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .soft_rst_i (soft_rst_i),
        .edge_i     (edge_w),
        .clr_i      (clr_w),
        .latch_o    (latch_w)
    );

    irq_reg_if #(.N_SRC(N_SRC)) u_regs (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .soft_rst_i (soft_rst_i),
        .bus_i      (bus),
        .latch_i    (latch_w),
        .clr_o      (clr_w),
        .pend_o     (pend_w),
        .rdata_o    (bus_rdata_o)
    );

    always_comb begin
        irq_o                      = |pend_w;
        status_bits_o              = '0;
        status_bits_o[STAT_PEND_B] = irq_o;
    end

    // R8
    irq_needs_latch_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        irq_o |-> (latch_w != '0));

endmodule

// File: tb/irq_mask_ctrl_tb.sv
module irq_mask_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       soft_rst = 1'b0;
    logic [6:0] req = '0;
    logic [7:0] addr = '0;
    logic       wr = 1'b0;
    logic       rd = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq;
    logic [7:0] stat;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    irq_mask_ctrl u_dut (
        .clk_i         (clk),
        .rst_i         (rst),
        .soft_rst_i    (soft_rst),
        .irq_req_i     (req),
        .bus_addr_i    (addr),
        .bus_wr_i      (wr),
        .bus_rd_i      (rd),
        .bus_wdata_i   (wdata),
        .bus_rdata_o   (rdata),
        .irq_o         (irq),
        .status_bits_o (stat)
    );

    task automatic check(input string req_tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req_tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd = 1'b1;
        #5 d = rdata;
        rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input logic [6:0] lines);
        @(negedge clk);
        req = req | lines;
        idle(3);
        req = req & ~lines;
        idle(3);
    endtask

    task automatic check_out(input string tag, input logic exp_irq);
        @(negedge clk);
        #5;
        check(tag, {7'd0, irq}, {7'd0, exp_irq});
        check(tag, stat, exp_irq ? 8'h04 : 8'h00);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        bus_read(8'h83, v); check("R1 mask", v, 8'h00);
        bus_read(8'h82, v); check("R1 pend", v, 8'h00);
        check_out("R1 irq/status", 1'b0);
    endtask

    task automatic t_masked_latch();
        logic [7:0] v;
        pulse(7'b000_0100);
        bus_read(8'h82, v); check("R3 masked pend", v, 8'h00);
        check_out("R3 masked irq", 1'b0);
        bus_write(8'h83, 8'h04);
        bus_read(8'h82, v); check("R3 opened pend", v, 8'h04);
        check_out("R8 irq on", 1'b1);
    endtask

    task automatic t_mask_patterns();
        logic [7:0] v;
        pulse(7'h7F);
        bus_read(8'h82, v); check("R5 mask 04", v, 8'h04);
        bus_write(8'h83, 8'hFF);
        bus_read(8'h83, v); check("R5 readback", v, 8'hFF);
        bus_read(8'h82, v); check("R4 all pass bit7 zero", v, 8'h7F);
        bus_write(8'h83, 8'h00);
        bus_read(8'h82, v); check("R5 mask 00", v, 8'h00);
        check_out("R8 irq off", 1'b0);
        bus_write(8'h83, 8'hA5);
        bus_read(8'h82, v); check("R4 and", v, 8'h25);
        bus_write(8'h83, 8'hFF);
    endtask

    task automatic t_clear();
        logic [7:0] v;
        bus_write(8'h82, 8'h04);
        bus_read(8'h82, v); check("R6 partial clear", v, 8'h7B);
        bus_read(8'h83, v); check("R6 mask unchanged", v, 8'hFF);
        bus_write(8'h82, 8'hFF);
        bus_read(8'h82, v); check("R6 full clear", v, 8'h00);
        check_out("R8 irq after clear", 1'b0);
    endtask

    task automatic t_level_hold();
        logic [7:0] v;
        @(negedge clk); req[0] = 1'b1;
        idle(4);
        bus_read(8'h82, v); check("R3 level latched", v, 8'h01);
        bus_write(8'h82, 8'h01);
        idle(3);
        bus_read(8'h82, v); check("R10 no reset while high", v, 8'h00);
        req[0] = 1'b0;
        idle(3);
    endtask

    task automatic t_collision();
        logic [7:0] v;
        @(negedge clk); req[4] = 1'b1;
        @(posedge clk);
        @(posedge clk);
        bus_write(8'h82, 8'h10);
        req[4] = 1'b0;
        bus_read(8'h82, v); check("R7 set beats clear", v, 8'h10);
        bus_write(8'h82, 8'h10);
        bus_read(8'h82, v); check("R7 later clear", v, 8'h00);
        idle(3);
    endtask

    task automatic t_unmapped();
        logic [7:0] v;
        pulse(7'b000_0010);
        bus_read(8'h81, v); check("R9 unmapped read", v, 8'h00);
        bus_write(8'h84, 8'h00);
        bus_write(8'h80, 8'hFF);
        bus_read(8'h83, v); check("R9 mask after unmapped write", v, 8'hFF);
        bus_read(8'h82, v); check("R9 latch after unmapped write", v, 8'h02);
        @(negedge clk); addr = 8'h82; #5;
        check("R9 idle rdata", rdata, 8'h00);
    endtask

    task automatic t_soft_reset();
        logic [7:0] v;
        @(negedge clk); soft_rst = 1'b1;
        @(negedge clk); soft_rst = 1'b0;
        bus_read(8'h83, v); check("R2 mask closed", v, 8'h00);
        check_out("R2 irq", 1'b0);
        bus_write(8'h83, 8'hFF);
        bus_read(8'h82, v); check("R2 latches empty", v, 8'h00);
    endtask

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);
        t_reset();
        t_masked_latch();
        t_mask_patterns();
        t_clear();
        t_level_hold();
        t_collision();
        t_unmapped();
        t_soft_reset();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule